// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier PWM Gate Generator

This block drives the ten gate signals of a single-phase, seven-level inverter leg. The leg is built from a high-frequency level stage that only ever produces non-negative voltage steps and a line-frequency full bridge that decides the output sign. A signed reference sample arrives with a strobe. The block takes its magnitude and compares that magnitude with one of three stacked sawtooth carriers. It then selects the switch set for the resulting level. The sign of the reference steers the full bridge.

All three carriers come from one up-counter whose period is set by an input. Band k covers magnitudes from k times the period up to (k+1) times the period. Within a band, the magnitude is compared against the counter value offset by the band base. A new reference takes effect only at the start of a carrier period, so at most one level decision is made per counter value. When the sign of the applied reference changes, the four bridge gates are all turned off for a programmable dead-time before the opposite diagonal pair is turned on.

Top module: `pdpwm_gate_gen`

## Requirements
- R1: While `rst` is high, all ten bits of `gate` are 0 at every sampled cycle. After release, the bridge pair settles to the forward pair for a zero reference.
- R2: The carrier counter runs from 0 to P-1 and then restarts, where P is `period` (0 is treated as 1). Band k (k = 0, 1, 2) covers reference magnitudes in the range [kP, (k+1)P).
- R3: Bit i of `gate` drives switch i+1. The level stage patterns in `gate[5:0]` are: level 0 = 6'b001110 (switches 2, 3, 4), level 1 = 6'b010110 (2, 3, 5), level 2 = 6'b110010 (2, 5, 6), level 3 = 6'b010001 (1, 5). No other pattern appears after reset.
- R4: A steady magnitude m = kP + r with 0 <= r < P and k < 3 gives level k+1 for exactly r cycles and level k for exactly P-r cycles of every carrier period.
- R5: A magnitude of 3P or more gives level 3 on every cycle. A magnitude of zero gives level 0 on every cycle. The most negative reference value is treated as the largest magnitude.
- R6: A reference of zero or above selects forward mode, `gate[9:6]` = 4'b0110 (switches 8, 9). A negative reference selects reverse mode, `gate[9:6]` = 4'b1001 (switches 7, 10). Mode depends only on the sign, never on the magnitude.
- R7: When the applied sign changes, `gate[9:6]` is 0 for exactly `dead_time`+1 consecutive cycles, and then the new pair turns on. The bridge never goes from one pair directly to the other.
- R8: Switches 7 and 8 (`gate[6]`, `gate[7]`) are never on together. Switches 9 and 10 (`gate[8]`, `gate[9]`) are never on together.
- R9: A reference strobed in the middle of a carrier period has no effect on `gate` until the next period begins. At that point it takes effect on the first cycle of the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | REF_W | Signed reference sample |
| ref_valid | input | 1 | Strobe that captures `ref_in` |
| period | input | CNT_W | Carrier period P in clock cycles |
| dead_time | input | DT_W | Bridge dead-time, applied as dead_time+1 off cycles |
| gate | output | 10 | Registered gate outputs; bit i drives switch i+1 |

## Verification
The bench builds the block with its default widths: a 12-bit reference, a 10-bit counter and a 6-bit dead-time. It drives a period of 20 and a dead-time of 3. With a period of 20, the full three-band range is 60 codes. One table can therefore reach every band, the lower and upper edge of each band, the clamp above 3P, and the most negative and most positive codes, all within a few carrier periods each. A single-count reference marks the start of a period at the outputs. This makes the deferred application of a new sample observable at the exact cycle. A short dead-time keeps each sign reversal within a window that the bench can count.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;
  localparam logic [5:0] LVL0_PAT = 6'b001110;
  localparam logic [5:0] LVL1_PAT = 6'b010110;
  localparam logic [5:0] LVL2_PAT = 6'b110010;
  localparam logic [5:0] LVL3_PAT = 6'b010001;
  localparam logic [3:0] BR_FWD   = 4'b0110;
  localparam logic [3:0] BR_REV   = 4'b1001;
  localparam logic [3:0] BR_OFF   = 4'b0000;

  function automatic logic [5:0] level_pattern(input logic [1:0] lvl);
    case (lvl)
      2'd0:    level_pattern = LVL0_PAT;
      2'd1:    level_pattern = LVL1_PAT;
      2'd2:    level_pattern = LVL2_PAT;
      default: level_pattern = LVL3_PAT;
    endcase
  endfunction
endpackage

// File: rtl/pdpwm_carrier.sv
module pdpwm_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_eff,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = (cnt >= period_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (wrap) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R2
endmodule

// File: rtl/pdpwm_level_sel.sv
module pdpwm_level_sel #(
  parameter int REF_W = 12,
  parameter int CNT_W = 10
) (
  input  logic [REF_W-1:0] mag,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period_eff,
  output logic [1:0]       level
);
  localparam int CMP_W = ((REF_W > CNT_W + 2) ? REF_W : CNT_W + 2) + 1;

  logic [CMP_W-1:0] m, c, p1, p2, p3, resid;
  logic [1:0]       band;

  always_comb begin
    m  = CMP_W'(mag);
    c  = CMP_W'(cnt);
    p1 = CMP_W'(period_eff);
    p2 = p1 << 1;
    p3 = p1 + p2;
    if (m >= p3) begin
      band  = 2'd3;
      resid = '0;
    end else if (m >= p2) begin
      band  = 2'd2;
      resid = m - p2;
    end else if (m >= p1) begin
      band  = 2'd1;
      resid = m - p1;
    end else begin
      band  = 2'd0;
      resid = m;
    end
    if (band == 2'd3)     level = 2'd3;
    else if (resid > c)   level = band + 2'd1;
    else                  level = band;
  end
endmodule

// File: rtl/pdpwm_bridge.sv
module pdpwm_bridge #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            want_neg,
  input  logic [DT_W-1:0] dead_time,
  output logic [3:0]      bridge
);
  import pdpwm_pkg::*;

  logic            cur_neg;
  logic            in_dead;
  logic [DT_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_neg <= 1'b0;
      in_dead <= 1'b1;
      dcnt    <= dead_time;
    end else if (in_dead) begin
      if (dcnt == '0) in_dead <= 1'b0;
      else            dcnt    <= dcnt - 1'b1;
    end else if (want_neg != cur_neg) begin
      cur_neg <= want_neg;
      in_dead <= 1'b1;
      dcnt    <= dead_time;
    end
  end

  always_comb begin
    if (in_dead)      bridge = BR_OFF;
    else if (cur_neg) bridge = BR_REV;
    else              bridge = BR_FWD;
  end

  AST_DEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_dead && dcnt != '0) |=> (bridge == BR_OFF)); // R7
endmodule

// File: rtl/pdpwm_gate_gen.sv
module pdpwm_gate_gen #(
  parameter int REF_W = 12,
  parameter int CNT_W = 10,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REF_W-1:0] ref_in,
  input  logic             ref_valid,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  dead_time,
  output logic [9:0]       gate
);
  import pdpwm_pkg::*;

  logic [CNT_W-1:0] period_eff, cnt;
  logic             wrap;
  logic [REF_W-1:0] pend_ref, act_ref, ref_abs;
  logic [1:0]       level;
  logic [3:0]       bridge;

  assign period_eff = (period == '0) ? CNT_W'(1) : period;

  pdpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk(clk), .rst(rst), .period_eff(period_eff), .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ref <= '0;
      act_ref  <= '0;
    end else begin
      if (ref_valid) pend_ref <= ref_in;
      if (wrap)      act_ref  <= pend_ref;
    end
  end

  assign ref_abs = act_ref[REF_W-1] ? (~act_ref + 1'b1) : act_ref;

  pdpwm_level_sel #(.REF_W(REF_W), .CNT_W(CNT_W)) u_level (
    .mag(ref_abs), .cnt(cnt), .period_eff(period_eff), .level(level)
  );

  pdpwm_bridge #(.DT_W(DT_W)) u_bridge (
    .clk(clk), .rst(rst), .want_neg(act_ref[REF_W-1]),
    .dead_time(dead_time), .bridge(bridge)
  );

  always_ff @(posedge clk) begin
    if (rst) gate <= '0;
    else     gate <= {bridge, level_pattern(level)};
  end

  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate[6] && gate[7])); // R8
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(gate[8] && gate[9])); // R8
  AST_NO_DIRECT_FWD_REV: assert property (@(posedge clk) disable iff (rst)
    (gate[9:6] == BR_FWD) |=> (gate[9:6] != BR_REV)); // R7
  AST_NO_DIRECT_REV_FWD: assert property (@(posedge clk) disable iff (rst)
    (gate[9:6] == BR_REV) |=> (gate[9:6] != BR_FWD)); // R7
  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (gate[5:0] == LVL0_PAT || gate[5:0] == LVL1_PAT ||
                     gate[5:0] == LVL2_PAT || gate[5:0] == LVL3_PAT)); // R3
endmodule

// File: tb/pdpwm_gate_gen_test.sv
`timescale 1ns/1ps
module pdpwm_gate_gen_test;
  localparam int P  = 20;
  localparam int DT = 3;
  localparam int NV = 10;
  // ref, higher level, cycles at higher level per period
  localparam int VEC [NV][3] = '{
    '{0,     1, 0},
    '{5,     1, 5},
    '{-13,   1, 13},
    '{20,    2, 0},
    '{27,    2, 7},
    '{-45,   3, 5},
    '{59,    3, 19},
    '{60,    3, 20},
    '{-2048, 3, 20},
    '{2047,  3, 20}
  };

  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] ref_in = '0;
  logic        ref_valid = 0;
  logic [9:0]  period = 10'(P);
  logic [5:0]  dead_time = 6'(DT);
  logic [9:0]  gate;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdpwm_gate_gen uut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_valid(ref_valid),
    .period(period), .dead_time(dead_time), .gate(gate)
  );

  function automatic logic [5:0] pat(input int l);
    case (l)
      0: pat = 6'b001110;
      1: pat = 6'b010110;
      2: pat = 6'b110010;
      default: pat = 6'b010001;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic apply(input int r);
    ref_in = 12'(r); ref_valid = 1;
    tick();
    ref_valid = 0;
  endtask

  initial begin
    int zrun;
    int t;
    int bad;
    tick(); tick();
    check("R1 reset gates low", int'(gate), 0);
    tick();
    check("R1 reset gates low", int'(gate), 0);
    rst = 0;
    repeat (P * 2) tick();
    check("R1 bridge forward after reset", int'(gate[9:6]), 4'b0110);

    for (int i = 0; i < NV; i++) begin
      int hi, lo, brbad, other, r;
      r = VEC[i][0];
      apply(r);
      repeat (3 * P + DT + 6) tick();
      hi = 0; lo = 0; brbad = 0; other = 0;
      for (int k = 0; k < P; k++) begin
        if (gate[5:0] == pat(VEC[i][1])) hi++;
        else if (gate[5:0] == pat(VEC[i][1] - 1)) lo++;
        else other++;
        if (gate[9:6] != ((r < 0) ? 4'b1001 : 4'b0110)) brbad++;
        tick();
      end
      if (r == 0 || r >= 60 || r <= -60) begin
        check("R5 high-level cycles", hi, VEC[i][2]);
        check("R5 stray patterns", other, 0);
      end else begin
        check("R4 high-level cycles", hi, VEC[i][2]);
        check("R4 low-level cycles", lo, P - VEC[i][2]);
      end
      check("R6 bridge mode", brbad, 0);
      check("R2 R3 pattern total", hi + lo + other, P);
    end

    // R7 dead-time on positive to negative reversal
    apply(7);
    repeat (3 * P + DT + 6) tick();
    apply(-7);
    t = 0;
    while (gate[9:6] == 4'b0110 && t < 4 * P) begin tick(); t++; end
    zrun = 0;
    while (gate[9:6] == 4'b0000 && zrun < 4 * P) begin tick(); zrun++; end
    check("R7 dead cycles pos->neg", zrun, DT + 1);
    check("R7 reverse pair after dead", int'(gate[9:6]), 4'b1001);
    check("R8 legs exclusive", int'((gate[6] & gate[7]) | (gate[8] & gate[9])), 0);

    // R7 with dead_time 0, negative to positive
    dead_time = 6'd0;
    apply(7);
    t = 0;
    while (gate[9:6] == 4'b1001 && t < 4 * P) begin tick(); t++; end
    zrun = 0;
    while (gate[9:6] == 4'b0000 && zrun < 4 * P) begin tick(); zrun++; end
    check("R7 dead cycles neg->pos zero setting", zrun, 1);
    check("R7 forward pair after dead", int'(gate[9:6]), 4'b0110);
    dead_time = 6'(DT);

    // R9 deferred application: one-count reference marks period start
    apply(1);
    repeat (3 * P) tick();
    t = 0;
    while (gate[5:0] != pat(1) && t < 4 * P) begin tick(); t++; end
    tick();
    apply(2047);
    bad = 0;
    for (int k = 2; k < P; k++) begin
      if (gate[5:0] != pat(0)) bad++;
      tick();
    end
    check("R9 no change before period start", bad, 0);
    check("R9 applied at period start", int'(gate[5:0]), int'(pat(3)));

    // R1 reset mid-run
    rst = 1;
    tick(); tick();
    check("R1 gates low in reset", int'(gate), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule